// File: doc/BRIEF.md
# Banked Interrupt Request Controller

This block collects level-sensitive interrupt requests from peripherals and presents them to a processor as one interrupt line per bank. The sources are grouped into `NUM_BANKS` identical banks of `SRC_W` sources each. In each bank a request sets a sticky pending bit, and the bit stays set until software clears it. A per-source enable register gates the pending bits. The bank's output line is raised whenever any enabled source is pending.

Software reaches every bank through a single-cycle register port. The banks repeat at a fixed byte stride of `STRIDE` (0x28 by default). Each bank has five registers:

- a raw pending register, written with ones to clear bits;
- the enable register;
- a read-only gated view (pending AND enable);
- a read-only view of the live request lines;
- a read-only register that names the highest-numbered enabled pending source.

The highest-numbered source wins, so software can pick the next source to service with one read. The usual start-up sequence writes zero to each enable register, then writes all ones to each raw register.

Top module: `bank_irq_ctrl`

## Requirements
- R1: A request input that is high at a rising clock edge sets its raw pending bit at that edge. The bit stays set after the request drops.
- R2: Writing the raw register (bank offset 0x00) clears every bit written as 1 and leaves every bit written as 0 unchanged. If a request is high in the same cycle as the clear, the request wins and the bit stays set.
- R3: The enable register (bank offset 0x08) is read/write. Only a write to this offset changes it.
- R4: The gated register (bank offset 0x10) reads raw AND enable. It reads zero when no enabled source is pending. Writes to it have no effect.
- R5: `irqOut[b]` equals the OR of bank b's raw AND enable as they stood one clock earlier. It is 0 whenever the enable register was all zero.
- R6: The live register (bank offset 0x18) reads the current request inputs of that bank. Writes to it have no effect.
- R7: The top-pending register (bank offset 0x20) reads bit 8 = 1 and bits 4:0 = the index of the highest-numbered set bit of the gated view. It reads zero when the gated view is zero.
- R8: Bank b occupies byte addresses b*STRIDE to b*STRIDE+STRIDE-1. `req` bits b*SRC_W to b*SRC_W+SRC_W-1 and `irqOut[b]` belong to bank b.
- R9: `rdData` holds the addressed register's value in the cycle after a clock edge that sampled `rdEn` high. After any edge with `rdEn` low it holds zero.
- R10: Reads of an offset that is not listed, or of an address past the last bank, return zero. Writes to such addresses change nothing.
- R11: Reset (`rstN` low) clears all raw and enable bits, `irqOut` and `rdData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wrData | input | SRC_W | Write data |
| rdData | output | SRC_W | Registered read data |
| req | input | NUM_BANKS*SRC_W | Level-high interrupt requests, bank-major |
| irqOut | output | NUM_BANKS | Registered per-bank interrupt line |

## Verification
The bench targets a clear that lands in the same cycle as a held request. A design that lets the clear win would drop an interrupt the peripheral still asserts. Several sources are made pending at once, some of them masked, and the top-pending value is checked against the expected priority. A lowest-first encoder, or one that looks at raw rather than gated bits, would report the wrong index.

Writes to read-only offsets, to unused offsets inside a bank, and to an address past the last bank are followed by read-back of the registers they could have corrupted. A decoder with loose offset matching would modify a neighbouring register. A distinct enable value in the last bank, together with a request pulse there, shows whether the bank base arithmetic and the output line index agree.

// File: rtl/birq_pkg.sv
package birq_pkg;
  localparam int BANK_IDX_W = 4;
  localparam int OFF_RAW    = 0;
  localparam int OFF_EN     = 8;
  localparam int OFF_GATED  = 16;
  localparam int OFF_LIVE   = 24;
  localparam int OFF_TOP    = 32;
  localparam int TOP_VALID_BIT = 8;

  typedef enum logic [2:0] {
    REG_NONE, REG_RAW, REG_EN, REG_GATED, REG_LIVE, REG_TOP
  } regKind_e;

  typedef struct packed {
    logic                  wr;
    logic                  rd;
    logic [BANK_IDX_W-1:0] bank;
    regKind_e              kind;
  } regStrobe_t;
endpackage

// File: rtl/birq_decode.sv
module birq_decode
  import birq_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int ADDR_W    = 8,
  parameter int STRIDE    = 40
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output regStrobe_t        strb
);
  always_comb begin
    int offs;
    offs = 0;
    strb = '{wr: wrEn, rd: rdEn, bank: '0, kind: REG_NONE};
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (int'(addr) >= b * STRIDE && int'(addr) < (b + 1) * STRIDE) begin
        offs = int'(addr) - b * STRIDE;
        strb.bank = BANK_IDX_W'(b);
        case (offs)
          OFF_RAW:   strb.kind = REG_RAW;
          OFF_EN:    strb.kind = REG_EN;
          OFF_GATED: strb.kind = REG_GATED;
          OFF_LIVE:  strb.kind = REG_LIVE;
          OFF_TOP:   strb.kind = REG_TOP;
          default:   strb.kind = REG_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/birq_datapath.sv
module birq_datapath
  import birq_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int SRC_W     = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  regStrobe_t                 strb,
  input  logic [SRC_W-1:0]           wrData,
  input  logic [NUM_BANKS*SRC_W-1:0] req,
  output logic [SRC_W-1:0]           rdData,
  output logic [NUM_BANKS-1:0]       irqOut,
  output logic [NUM_BANKS*SRC_W-1:0] statusFlat,
  output logic [NUM_BANKS*SRC_W-1:0] enableFlat
);
  localparam int IDX_W = $clog2(SRC_W);

  logic [SRC_W-1:0] bankVal [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [SRC_W-1:0] stat, en, clr, gated, top, live;
    logic             irqQ, selB;

    assign selB  = (strb.bank == BANK_IDX_W'(b));
    assign live  = req[b*SRC_W +: SRC_W];
    assign clr   = (strb.wr && selB && strb.kind == REG_RAW) ? wrData : '0;
    assign gated = stat & en;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stat <= '0;
        en   <= '0;
        irqQ <= 1'b0;
      end else begin
        stat <= (stat & ~clr) | live;
        if (strb.wr && selB && strb.kind == REG_EN) en <= wrData;
        irqQ <= |gated;
      end
    end

    always_comb begin
      top = '0;
      for (int i = 0; i < SRC_W; i++) begin
        if (gated[i]) begin
          top = '0;
          top[TOP_VALID_BIT] = 1'b1;
          top[IDX_W-1:0] = IDX_W'(i);
        end
      end
    end

    always_comb begin
      bankVal[b] = '0;
      if (selB) begin
        case (strb.kind)
          REG_RAW:   bankVal[b] = stat;
          REG_EN:    bankVal[b] = en;
          REG_GATED: bankVal[b] = gated;
          REG_LIVE:  bankVal[b] = live;
          REG_TOP:   bankVal[b] = top;
          default:   bankVal[b] = '0;
        endcase
      end
    end

    assign irqOut[b] = irqQ;
    assign statusFlat[b*SRC_W +: SRC_W] = stat;
    assign enableFlat[b*SRC_W +: SRC_W] = en;
  end

  logic [SRC_W-1:0] rdNext;
  always_comb begin
    rdNext = '0;
    for (int b = 0; b < NUM_BANKS; b++) rdNext = rdNext | bankVal[b];
  end

  always_ff @(posedge clk) begin
    if (!rstN)        rdData <= '0;
    else if (strb.rd) rdData <= rdNext;
    else              rdData <= '0;
  end
endmodule

// File: rtl/bank_irq_ctrl.sv
module bank_irq_ctrl
  import birq_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int SRC_W     = 32,
  parameter int STRIDE    = 40,
  parameter int ADDR_W    = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic                       rdEn,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [SRC_W-1:0]           wrData,
  output logic [SRC_W-1:0]           rdData,
  input  logic [NUM_BANKS*SRC_W-1:0] req,
  output logic [NUM_BANKS-1:0]       irqOut
);
  regStrobe_t                 strb;
  logic [NUM_BANKS*SRC_W-1:0] statusFlat;
  logic [NUM_BANKS*SRC_W-1:0] enableFlat;

  birq_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_decode (
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .strb(strb)
  );

  birq_datapath #(.NUM_BANKS(NUM_BANKS), .SRC_W(SRC_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .req(req),
    .rdData(rdData), .irqOut(irqOut),
    .statusFlat(statusFlat), .enableFlat(enableFlat)
  );
endmodule

// File: rtl/birq_checker.sv
module birq_checker #(
  parameter int NUM_BANKS = 5,
  parameter int SRC_W     = 32
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       wrEn,
  input logic                       rdEn,
  input logic [SRC_W-1:0]           rdData,
  input logic [NUM_BANKS*SRC_W-1:0] req,
  input logic [NUM_BANKS-1:0]       irqOut,
  input logic [NUM_BANKS*SRC_W-1:0] statusFlat,
  input logic [NUM_BANKS*SRC_W-1:0] enableFlat
);
  AST_REQ_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (req != '0) |=> ((statusFlat & $past(req)) == $past(req))); // R1
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ((statusFlat & $past(statusFlat)) == $past(statusFlat))); // R2
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(enableFlat)); // R3
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (enableFlat == '0) |=> (irqOut == '0)); // R5
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> (rdData == '0)); // R9
endmodule

bind bank_irq_ctrl birq_checker #(.NUM_BANKS(NUM_BANKS), .SRC_W(SRC_W)) u_chk (.*);

// File: tb/bank_irq_ctrl_bench.sv
module bank_irq_ctrl_bench;
  localparam int NB = 5;
  localparam int SW = 32;
  localparam int ST = 40;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]    addr = '0;
  logic [SW-1:0] wrData = '0;
  logic [SW-1:0] rdData;
  logic [NB*SW-1:0] req = '0;
  logic [NB-1:0] irqOut;

  int nRun = 0, nFail = 0;
  bit done = 0;

  bank_irq_ctrl #(.NUM_BANKS(NB), .SRC_W(SW), .STRIDE(ST), .ADDR_W(8)) u_bank_irq_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .req(req), .irqOut(irqOut)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  logic [SW-1:0] mStat [NB];
  logic [SW-1:0] mEn   [NB];
  logic [NB-1:0] mIrq;
  logic [SW-1:0] mRd;

  function automatic logic [SW-1:0] modelRead(input int a);
    int bk, off;
    logic [SW-1:0] g, t;
    bk = a / ST; off = a % ST;
    if (bk >= NB) return '0;
    g = mStat[bk] & mEn[bk];
    t = '0;
    for (int i = SW - 1; i >= 0; i--) if (g[i] && t == '0) t = 32'h100 | i;
    case (off)
      0: return mStat[bk];
      8: return mEn[bk];
      16: return g;
      24: return req[bk*SW +: SW];
      32: return t;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NB; b++) begin mStat[b] = '0; mEn[b] = '0; end
      mIrq = '0; mRd = '0;
    end else begin
      logic [NB-1:0] nIrq;
      mRd = rdEn ? modelRead(int'(addr)) : '0;
      for (int b = 0; b < NB; b++) nIrq[b] = |(mStat[b] & mEn[b]);
      if (wrEn && int'(addr) / ST < NB) begin
        if (int'(addr) % ST == 0) mStat[int'(addr) / ST] &= ~wrData;
        if (int'(addr) % ST == 8) mEn[int'(addr) / ST] = wrData;
      end
      for (int b = 0; b < NB; b++) mStat[b] |= req[b*SW +: SW];
      mIrq = nIrq;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(irqOut == mIrq, "R5 irqOut vs model", SW'(irqOut), SW'(mIrq));
      chk(rdData == mRd, "R9 rdData vs model", rdData, mRd);
    end
  end

  task automatic wrReg(input int a, input logic [SW-1:0] d);
    @(negedge clk); addr = 8'(a); wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdExpect(input int a, input logic [SW-1:0] exp, input string tag);
    @(negedge clk); addr = 8'(a); rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
    chk(rdData == exp, tag, rdData, exp);
  endtask

  task automatic setReq(input int b, input logic [SW-1:0] v);
    @(negedge clk); req[b*SW +: SW] = v;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      nRun++; nFail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(irqOut == '0, "R11 irq after reset", SW'(irqOut), '0);
    chk(rdData == '0, "R11 rdData after reset", rdData, '0);
    rdExpect(0, '0, "R11 raw bank0 reset");
    rdExpect(8, '0, "R11 enable bank0 reset");

    // R3 enable read/write
    wrReg(ST + 8, 32'hFFFF_0000);
    rdExpect(ST + 8, 32'hFFFF_0000, "R3 enable bank1 readback");

    // R1 latch on a one-cycle pulse
    setReq(1, 32'h0010_0000); setReq(1, '0);
    rdExpect(ST, 32'h0010_0000, "R1 raw sticky after pulse");
    chk(irqOut[1] == 1'b1, "R5 bank1 line high", SW'(irqOut), 32'h2);
    rdExpect(ST + 16, 32'h0010_0000, "R4 gated view");
    rdExpect(ST + 32, 32'h114, "R7 top pending 20");

    // R4 masked source does not reach gated view
    setReq(1, 32'h8); setReq(1, '0);
    rdExpect(ST, 32'h0010_0008, "R1 raw two bits");
    rdExpect(ST + 16, 32'h0010_0000, "R4 masked bit absent");
    setReq(1, 32'h0200_0000); setReq(1, '0);
    rdExpect(ST + 32, 32'h119, "R7 highest index wins");

    // R2 write-one-to-clear
    wrReg(ST, 32'h0200_0000);
    rdExpect(ST, 32'h0010_0008, "R2 clear one bit");
    wrReg(ST, '0);
    rdExpect(ST, 32'h0010_0008, "R2 zero write no effect");
    setReq(1, 32'h0010_0000);
    wrReg(ST, 32'h0010_0000);
    rdExpect(ST, 32'h0010_0008, "R2 request wins over clear");
    setReq(1, '0);
    wrReg(ST, 32'h0010_0000);
    rdExpect(ST, 32'h8, "R2 clear after request drops");
    rdExpect(ST + 32, '0, "R7 top zero when none gated");
    rdExpect(ST + 16, '0, "R4 gated zero");
    chk(irqOut == '0, "R5 lines low", SW'(irqOut), '0);

    // R6 live view, R10 read-only writes ignored
    setReq(2, 32'hA5);
    rdExpect(2*ST + 24, 32'hA5, "R6 live request view");
    wrReg(2*ST + 24, '1);
    wrReg(2*ST + 16, '1);
    wrReg(2*ST + 32, '1);
    rdExpect(2*ST, 32'hA5, "R10 raw untouched by read-only writes");
    rdExpect(2*ST + 8, '0, "R10 enable untouched by read-only writes");
    setReq(2, '0);
    rdExpect(2*ST + 24, '0, "R6 live view follows drop");
    wrReg(2*ST, '1);
    rdExpect(2*ST, '0, "R2 clear all");

    // R10 unmapped offsets and addresses
    rdExpect(ST + 4, '0, "R10 unused offset reads zero");
    wrReg(ST + 4, '0);
    wrReg(9, '1);
    wrReg(NB*ST, '1);
    wrReg(NB*ST + 8, '1);
    rdExpect(ST + 8, 32'hFFFF_0000, "R10 bank1 enable intact");
    rdExpect(ST, 32'h8, "R10 bank1 raw intact");
    rdExpect(8, '0, "R10 bank0 enable intact");
    rdExpect(NB*ST + 8, '0, "R10 past last bank reads zero");

    // R8 bank mapping
    wrReg(4*ST + 8, 32'h1234_5678);
    for (int b = 0; b < NB; b++)
      rdExpect(b*ST + 8, (b == 4) ? 32'h1234_5678 : (b == 1) ? 32'hFFFF_0000 : 32'h0, "R8 enable per bank");
    setReq(4, 32'h10); setReq(4, '0);
    @(negedge clk);
    chk(irqOut == 5'b10000, "R8 line of bank4", SW'(irqOut), 32'h10);
    rdExpect(4*ST + 32, 32'h104, "R8 top pending bank4");
    wrReg(4*ST + 8, '0);
    @(negedge clk); @(negedge clk);
    chk(irqOut == '0, "R5 line drops after disable", SW'(irqOut), '0);
    chk(rdData == '0, "R9 idle read data zero", rdData, '0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule